// File: doc/BRIEF.md
# Range-Bound Comparator

This block tests whether a 32-bit register operand falls inside an inclusive window set by a lower and an upper bound. It takes the operand, the two bounds, an operand size (byte, word or long) and a flag telling whether the operand comes from a data register or an address register. One cycle after an input strobe it returns an updated five-bit condition-code vector and an out-of-range flag.

Narrow bounds are sign-extended to 32 bits first. A data-register operand is sign-extended in the same way. An address-register operand is always used at its full 32 bits.

The range test is one unsigned comparison of two offsets: (operand minus lower) against (upper minus lower). Both differences are taken modulo 2^32. A pipeline uses the registered out-of-range flag to decide on a bounds trap. It merges the returned condition codes into its status state.

Top module: `rangechk_unit`

## Requirements
- R1: Each bound is sign-extended to 32 bits from the selected size. size_i = 0 selects byte, which uses bits 7:0. size_i = 1 selects word, which uses bits 15:0. size_i = 2 selects long, and the bound is used unchanged.
- R2: When addr_reg_i = 0 (data register), the operand is sign-extended from the selected size. When addr_reg_i = 1 (address register), all 32 operand bits are used unchanged for every size.
- R3: Z (flags_o bit 2) is 1 exactly when the extended operand equals the extended lower bound or the extended upper bound.
- R4: C (flags_o bit 0) is 1 exactly when (operand - lower) mod 2^32, read as unsigned, is greater than (upper - lower) mod 2^32. When the lower bound is above the upper bound, this makes the window wrap around through zero.
- R5: X (bit 4), N (bit 3) and V (bit 1) of flags_o copy the same bits of flags_i. Bits 2 and 0 of flags_i have no effect on the output.
- R6: The condition-code bit order is X=4, N=3, Z=2, V=1, C=0, on both flags_i and flags_o.
- R7: out_of_range_o always equals flags_o bit 0.
- R8: A result appears on the clock edge that samples in_valid = 1, and out_valid_o is 1 for that result. While in_valid = 0, out_valid_o is 0 and flags_o and out_of_range_o hold their last values.
- R9: After reset, out_valid_o, flags_o and out_of_range_o are all zero.
- R10: size_i = 3 behaves exactly like long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input strobe |
| value_i | input | 32 | Register operand |
| lo_bound_i | input | 32 | Lower bound, in the low bits for narrow sizes |
| hi_bound_i | input | 32 | Upper bound, in the low bits for narrow sizes |
| size_i | input | 2 | 0 byte, 1 word, 2 or 3 long |
| addr_reg_i | input | 1 | 1 = address register operand (no extension) |
| flags_i | input | 5 | Incoming condition codes {X,N,Z,V,C} |
| out_valid_o | output | 1 | Result strobe |
| flags_o | output | 5 | Updated condition codes {X,N,Z,V,C} |
| out_of_range_o | output | 1 | Out-of-range indication |

## Verification
The bench places garbage in the upper operand bits under byte and word sizes and checks that data and address registers give different results. A design that ignored the register type, or failed to extend the operand, would produce a spurious equality or a flipped C bit. It drives a wrapped window (lower above upper) both inside and outside the window. It also hits each bound exactly, where an off-by-one comparison would report the bound as out of range. Incoming Z and C bits are set to catch a design that leaks them through. Size code 3 and the hold behaviour between strobes are also checked.

// File: rtl/rangechk_pkg.sv
package rangechk_pkg;

    localparam int CC_W = 5;
    localparam int CC_X = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_FULL = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    typedef struct packed {
        logic            vld;
        logic [CC_W-1:0] ccr;
        logic            oor;
    } rc_state_t;

endpackage

// File: rtl/rc_sext.sv
module rc_sext
    import rangechk_pkg::*;
#(
    parameter int W  = 32,
    parameter int BW = 8,
    parameter int HW = 16
) (
    input  logic [W-1:0] raw_i,
    input  size_e        size_i,
    input  logic         bypass_i,
    output logic [W-1:0] ext_o
);
    localparam int BPAD = W - BW;
    localparam int HPAD = W - HW;

    logic [W-1:0] from_byte;
    logic [W-1:0] from_half;

    assign from_byte = {{BPAD{raw_i[BW-1]}}, raw_i[BW-1:0]};
    assign from_half = {{HPAD{raw_i[HW-1]}}, raw_i[HW-1:0]};

    always_comb begin
        if (bypass_i) begin
            ext_o = raw_i;
        end else begin
            unique case (size_i)
                SZ_BYTE: ext_o = from_byte;
                SZ_HALF: ext_o = from_half;
                default: ext_o = raw_i;   // long and the spare code
            endcase
        end
    end
endmodule

// File: rtl/rc_offset_cmp.sv
module rc_offset_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic         hit_bound_o,
    output logic         outside_o
);
    logic [W-1:0] offset;
    logic [W-1:0] span;

    // modulo-2^W differences; a wrapped window falls out naturally
    assign offset      = opnd_i - lo_i;
    assign span        = hi_i - lo_i;
    assign outside_o   = offset > span;
    assign hit_bound_o = (opnd_i == lo_i) || (opnd_i == hi_i);
endmodule

// File: rtl/rangechk_unit.sv
module rangechk_unit
    import rangechk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] value_i,
    input  logic [DATA_W-1:0] lo_bound_i,
    input  logic [DATA_W-1:0] hi_bound_i,
    input  logic [1:0]        size_i,
    input  logic              addr_reg_i,
    input  logic [CC_W-1:0]   flags_i,
    output logic              out_valid_o,
    output logic [CC_W-1:0]   flags_o,
    output logic              out_of_range_o
);
    localparam int NUM_EXT = 3;   // operand, lower, upper

    size_e             size_sel;
    logic [DATA_W-1:0] raw_arr  [NUM_EXT];
    logic [DATA_W-1:0] ext_arr  [NUM_EXT];
    logic              byp_arr  [NUM_EXT];
    logic              hit_bound;
    logic              outside;
    rc_state_t         st_d, st_q;

    assign size_sel   = size_e'(size_i);
    assign raw_arr[0] = value_i;
    assign raw_arr[1] = lo_bound_i;
    assign raw_arr[2] = hi_bound_i;
    assign byp_arr[0] = addr_reg_i;   // address registers are never extended
    assign byp_arr[1] = 1'b0;
    assign byp_arr[2] = 1'b0;

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        rc_sext #(.W(DATA_W), .BW(BYTE_W), .HW(HALF_W)) u_sext (
            .raw_i    (raw_arr[g]),
            .size_i   (size_sel),
            .bypass_i (byp_arr[g]),
            .ext_o    (ext_arr[g])
        );
    end

    rc_offset_cmp #(.W(DATA_W)) u_cmp (
        .opnd_i      (ext_arr[0]),
        .lo_i        (ext_arr[1]),
        .hi_i        (ext_arr[2]),
        .hit_bound_o (hit_bound),
        .outside_o   (outside)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ccr       = flags_i;     // X, N, V pass through
            st_d.ccr[CC_Z] = hit_bound;
            st_d.ccr[CC_C] = outside;
            st_d.oor       = outside;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o    = st_q.vld;
    assign flags_o        = st_q.ccr;
    assign out_of_range_o = st_q.oor;

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(flags_o) && $stable(out_of_range_o) && !out_valid_o));

    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (flags_o[CC_X] == $past(flags_i[CC_X]) &&
                      flags_o[CC_N] == $past(flags_i[CC_N]) &&
                      flags_o[CC_V] == $past(flags_i[CC_V])));

    p_z_on_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_i == 2'd2 && value_i == lo_bound_i) |=> flags_o[CC_Z]);

    p_lo_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_i == 2'd2 && value_i == lo_bound_i) |=> !flags_o[CC_C]);

    p_oor_is_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_of_range_o == flags_o[CC_C]));
endmodule

// File: tb/rangechk_unit_bench.sv
module rangechk_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] value_i = '0;
    logic [31:0] lo_bound_i = '0;
    logic [31:0] hi_bound_i = '0;
    logic [1:0]  size_i = '0;
    logic        addr_reg_i = 1'b0;
    logic [4:0]  flags_i = '0;
    logic        out_valid_o;
    logic [4:0]  flags_o;
    logic        out_of_range_o;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;   // 125 MHz

    rangechk_unit u_rangechk_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .value_i(value_i),
        .lo_bound_i(lo_bound_i), .hi_bound_i(hi_bound_i), .size_i(size_i),
        .addr_reg_i(addr_reg_i), .flags_i(flags_i), .out_valid_o(out_valid_o),
        .flags_o(flags_o), .out_of_range_o(out_of_range_o)
    );

    function automatic logic [31:0] sx(input logic [31:0] x, input logic [1:0] sz);
        case (sz)
            2'd0:    return {{24{x[7]}}, x[7:0]};
            2'd1:    return {{16{x[15]}}, x[15:0]};
            default: return x;
        endcase
    endfunction

    // expected {flags, oor} from the requirements
    function automatic logic [5:0] model(input logic [31:0] v, lo, hi,
                                         input logic [1:0] sz, input logic ar,
                                         input logic [4:0] f);
        logic [31:0] ev, el, eh;
        logic z, c;
        ev = ar ? v : sx(v, sz);
        el = sx(lo, sz);
        eh = sx(hi, sz);
        z  = (ev == el) || (ev == eh);
        c  = (ev - el) > (eh - el);
        return {f[4], f[3], z, f[1], c, c};
    endfunction

    task automatic drive(input logic [31:0] v, lo, hi, input logic [1:0] sz,
                         input logic ar, input logic [4:0] f, input string tag);
        exp_q.push_back(model(v, lo, hi, sz, ar, f));
        tag_q.push_back(tag);
        value_i = v; lo_bound_i = lo; hi_bound_i = hi;
        size_i = sz; addr_reg_i = ar; flags_i = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [5:0] act, exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp_v);
        end
    endtask

    // monitor: compares results away from the rising edge
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", {flags_o, out_of_range_o}, 6'h0);
            end else begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({flags_o, out_of_range_o} == e, t, {flags_o, out_of_range_o}, e);
                check(out_of_range_o == flags_o[0], "R7 oor equals C",
                      {5'b0, out_of_range_o}, {5'b0, flags_o[0]});
            end
        end
    end

    initial begin
        #1_000_000;
        check(1'b0, "watchdog expired", 6'h0, 6'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] held;
        repeat (3) @(negedge clk);
        check({out_valid_o, flags_o, out_of_range_o} == 7'b0, "R9 reset state",
              {flags_o, out_of_range_o}, 6'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: byte data register, upper operand bits garbage, equals lower bound
        drive(32'h1234_5680, 32'h0000_0080, 32'h0000_007F, 2'd0, 1'b0, 5'b00000, "R1 R2 R3 byte data on lo");
        // R2: same operand as address register uses all 32 bits -> outside
        drive(32'h1234_5680, 32'h0000_0080, 32'h0000_007F, 2'd0, 1'b1, 5'b00000, "R2 byte address reg");
        // R1: word data -1 inside [-16,16]
        drive(32'h0000_FFFF, 32'h0000_FFF0, 32'h0000_0010, 2'd1, 1'b0, 5'b10000, "R1 word data inside");
        // R2: word address reg 0x8000 vs extended -32768
        drive(32'h0000_8000, 32'h0000_8000, 32'h0000_7FFF, 2'd1, 1'b1, 5'b00000, "R2 word address reg");
        // R4: long above range
        drive(32'd100, 32'd10, 32'd50, 2'd2, 1'b0, 5'b01010, "R4 R5 long above");
        // R4: long below range
        drive(32'd5, 32'd10, 32'd50, 2'd2, 1'b0, 5'b00101, "R4 R5 long below, incoming Z C ignored");
        // R3: equals upper bound
        drive(32'd50, 32'd10, 32'd50, 2'd2, 1'b0, 5'b11111, "R3 R6 long on hi");
        // R4: wrapped window
        drive(32'd5, 32'hFFFF_FFF0, 32'h0000_0010, 2'd2, 1'b0, 5'b00000, "R4 wrapped inside");
        drive(32'h20, 32'hFFFF_FFF0, 32'h0000_0010, 2'd2, 1'b0, 5'b00000, "R4 wrapped outside");
        // R10: spare size code acts as long
        drive(32'h1234_5680, 32'h1234_5600, 32'h1234_56FF, 2'd3, 1'b0, 5'b00000, "R10 size 3 inside");
        drive(32'h0000_0080, 32'h1234_5600, 32'h1234_56FF, 2'd3, 1'b0, 5'b00000, "R10 size 3 outside");
        // R4: byte wrap with lo above hi
        drive(32'h0000_0000, 32'h0000_0010, 32'h0000_00F0, 2'd0, 1'b0, 5'b00000, "R4 byte lo above hi");
        @(negedge clk);

        // R8: hold with changed inputs and no strobe
        held = {flags_o, out_of_range_o};
        value_i = 32'hDEAD_BEEF; flags_i = 5'b11111; size_i = 2'd0;
        repeat (3) @(negedge clk);
        check({flags_o, out_of_range_o} == held && !out_valid_o, "R8 hold without strobe",
              {flags_o, out_of_range_o}, held);
        check(exp_q.size() == 0, "R8 all results seen", 6'(exp_q.size()), 6'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule